// File: doc/BRIEF.md
# Sampled Control Loop Sequencer

This block paces one digital control loop through its three stages in a fixed order: analog-to-digital conversion, the PID arithmetic, and the digital-to-analog write. It starts a conversion and then blocks until the converter raises its end-of-conversion flag. It then latches the sample and starts the PID datapath. When the datapath reports a valid result, it pulls the active-low converter write strobe low for one clock. After the write it starts the next conversion at once, so the loop runs without a break.

Every output is decoded from the registered state alone, so the outputs are glitch-free and follow their causing inputs by one clock. When both flags are already high, a full loop takes five system clocks. A 120 MHz clock therefore gives a 24 MHz sample rate. A parameter selects a binary or a one-hot state register, and both give the same behaviour at the ports.

Top module: `loop_sequencer`

## Requirements
- R1: A synchronous reset puts the machine in its idle state. While reset holds and in the cycle after it, `dac_wr_n` is 1 and `conv_start`, `sample_le` and `pid_go` are 0. Reset taken in the middle of a loop aborts that loop.
- R2: The first clock edge after reset is released moves the machine from idle to the start state. `conv_start` is high for exactly one clock per loop.
- R3: After the start state the machine waits with all strobes low and `dac_wr_n` high, for as long as `eoc` is sampled low.
- R4: The clock edge that samples `eoc` high while waiting makes `sample_le` high for exactly one clock.
- R5: `pid_go` rises in the clock after `sample_le` and stays high until the edge that samples `pid_done` high.
- R6: The edge that samples `pid_done` high while `pid_go` is high drives `dac_wr_n` low for exactly one clock. The next clock has `conv_start` high.
- R7: With `eoc` and `pid_done` held high, consecutive `conv_start` pulses are five clocks apart.
- R8: At most one of `conv_start`, `sample_le`, `pid_go` and the inverted `dac_wr_n` is active in any cycle.
- R9: `eoc` has no effect outside the wait for conversion, and `pid_done` has no effect outside the PID wait. When both are high together while waiting for conversion, the machine only advances to the latch step.
- R10: The binary state register (`ONE_HOT`=0) and the one-hot state register (`ONE_HOT`=1) give identical output sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| eoc | input | 1 | Converter end-of-conversion flag |
| pid_done | input | 1 | PID datapath result valid |
| conv_start | output | 1 | Starts a conversion, one-clock pulse |
| sample_le | output | 1 | Latch enable for the converted sample |
| pid_go | output | 1 | Input strobe to the PID datapath, held while waiting |
| dac_wr_n | output | 1 | Output converter write, active low |

## Verification
The case that needs the most care is `eoc` and `pid_done` both high in the same cycle. Only one of them belongs to the current state. The bench raises both while the machine waits for conversion and expects only the latch step, and one clock later the PID strobe with no write. It then raises `eoc` alone during the PID wait and expects `pid_go` to stay high. A binary and a one-hot instance run side by side, and every check compares the two.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int NUM_PHASES = 6;
   localparam int PHASE_W    = $clog2(NUM_PHASES);

   typedef enum logic [PHASE_W-1:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_WAIT  = 3'd2,
      PH_LATCH = 3'd3,
      PH_CALC  = 3'd4,
      PH_WRITE = 3'd5
   } phase_e;
endpackage

// File: rtl/seq_next.sv
module seq_next
   import seq_pkg::*;
(
   input  phase_e cur_i,
   input  logic   eoc_i,
   input  logic   done_i,
   output phase_e nxt_o
);
   always_comb begin
      unique case (cur_i)
         PH_IDLE:  nxt_o = PH_START;
         PH_START: nxt_o = PH_WAIT;
         PH_WAIT:  nxt_o = eoc_i ? PH_LATCH : PH_WAIT;
         PH_LATCH: nxt_o = PH_CALC;
         PH_CALC:  nxt_o = done_i ? PH_WRITE : PH_CALC;
         PH_WRITE: nxt_o = PH_START;
         default:  nxt_o = PH_IDLE;
      endcase
   end
endmodule

// File: rtl/seq_state_store.sv
module seq_state_store
   import seq_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic   clk,
   input  logic   rst,
   input  phase_e nxt_i,
   output phase_e cur_o
);
   generate
      if (ONE_HOT) begin : g_hot
         logic [NUM_PHASES-1:0] hot_q;
         logic [NUM_PHASES-1:0] hot_d;

         always_comb begin
            hot_d = '0;
            hot_d[nxt_i] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               hot_q <= '0;
               hot_q[PH_IDLE] <= 1'b1;
            end else begin
               hot_q <= hot_d;
            end
         end

         always_comb begin
            cur_o = PH_IDLE;
            for (int i = 0; i < NUM_PHASES; i++) begin
               if (hot_q[i]) cur_o = phase_e'(i[PHASE_W-1:0]);
            end
         end

         AST_HOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
            $onehot(hot_q)) else $error("one-hot state lost"); // R10
      end else begin : g_bin
         phase_e bin_q;

         always_ff @(posedge clk) begin
            if (rst) bin_q <= PH_IDLE;
            else     bin_q <= nxt_i;
         end

         assign cur_o = bin_q;
      end
   endgenerate
endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
   import seq_pkg::*;
(
   input  phase_e cur_i,
   output logic   conv_start_o,
   output logic   sample_le_o,
   output logic   pid_go_o,
   output logic   dac_wr_n_o
);
   always_comb begin
      conv_start_o = (cur_i == PH_START);
      sample_le_o  = (cur_i == PH_LATCH);
      pid_go_o     = (cur_i == PH_CALC);
      dac_wr_n_o   = (cur_i != PH_WRITE);
   end
endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
   import seq_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic eoc,
   input  logic pid_done,
   output logic conv_start,
   output logic sample_le,
   output logic pid_go,
   output logic dac_wr_n
);
   generate
      if (NUM_PHASES > (1 << PHASE_W)) begin : g_bad_width
         $error("phase width too small for the phase count");
      end
   endgenerate

   phase_e cur;
   phase_e nxt;

   seq_next u_next (
      .cur_i  (cur),
      .eoc_i  (eoc),
      .done_i (pid_done),
      .nxt_o  (nxt)
   );

   seq_state_store #(.ONE_HOT(ONE_HOT)) u_store (
      .clk   (clk),
      .rst   (rst),
      .nxt_i (nxt),
      .cur_o (cur)
   );

   seq_out_decode u_dec (
      .cur_i        (cur),
      .conv_start_o (conv_start),
      .sample_le_o  (sample_le),
      .pid_go_o     (pid_go),
      .dac_wr_n_o   (dac_wr_n)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |=> (dac_wr_n && !conv_start && !sample_le && !pid_go)) else $error("reset outputs"); // R1
   AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
      conv_start |=> !conv_start) else $error("start longer than one clock"); // R2
   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_WAIT && !eoc) |=> (cur == PH_WAIT && !sample_le)) else $error("left wait early"); // R3
   AST_LATCH_ON_EOC: assert property (@(posedge clk) disable iff (rst)
      (cur == PH_WAIT && eoc) |=> sample_le) else $error("no latch after eoc"); // R4
   AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
      sample_le |=> (!sample_le && pid_go)) else $error("latch/go order"); // R5
   AST_GO_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (pid_go && !pid_done) |=> pid_go) else $error("go dropped early"); // R5
   AST_WRITE_ON_DONE: assert property (@(posedge clk) disable iff (rst)
      (pid_go && pid_done) |=> !dac_wr_n) else $error("no write after done"); // R6
   AST_WRITE_THEN_START: assert property (@(posedge clk) disable iff (rst)
      !dac_wr_n |=> (dac_wr_n && conv_start)) else $error("write not followed by start"); // R6
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0({conv_start, sample_le, pid_go, !dac_wr_n})) else $error("overlapping strobes"); // R8
   AST_EOC_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (pid_go && !pid_done) |=> !sample_le) else $error("eoc acted in compute"); // R9
endmodule

// File: tb/sim_loop_sequencer.sv
`timescale 1ns/1ps
module sim_loop_sequencer;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic eoc = 1'b0;
   logic pid_done = 1'b0;
   logic cs0, le0, go0, wr0;
   logic cs1, le1, go1, wr1;
   int   tests = 0;
   int   fails = 0;
   bit   finished = 1'b0;

   // output vector {conv_start, sample_le, pid_go, dac_wr_n}; R8: at most one active
   localparam logic [3:0] V_IDLE  = 4'b0001;
   localparam logic [3:0] V_START = 4'b1001;
   localparam logic [3:0] V_LATCH = 4'b0101;
   localparam logic [3:0] V_CALC  = 4'b0011;
   localparam logic [3:0] V_WRITE = 4'b0000;

   always #2.5 clk = ~clk;

   loop_sequencer #(.ONE_HOT(1'b0)) u0 (
      .clk(clk), .rst(rst), .eoc(eoc), .pid_done(pid_done),
      .conv_start(cs0), .sample_le(le0), .pid_go(go0), .dac_wr_n(wr0));

   loop_sequencer #(.ONE_HOT(1'b1)) u1 (
      .clk(clk), .rst(rst), .eoc(eoc), .pid_done(pid_done),
      .conv_start(cs1), .sample_le(le1), .pid_go(go1), .dac_wr_n(wr1));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] a0, a1;
      a0 = {cs0, le0, go0, wr0};
      a1 = {cs1, le1, go1, wr1};
      tests++;
      if (a0 !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, a0, exp);
      end
      tests++;
      if (a1 !== a0) begin
         fails++;
         $display("FAIL R10 (%s): one-hot %b expected %b", req, a1, a0);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; eoc = 1'b0; pid_done = 1'b0;
      tick(); tick();
      chk("R1 reset", V_IDLE);
      rst = 1'b0;
      tick();
      chk("R2 first start", V_START);
   endtask

   task automatic t_single_loop();
      tick();
      chk("R2 start one clock", V_IDLE);
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R3 waiting", V_IDLE);
      end
      eoc = 1'b1;
      tick();
      chk("R4 latch", V_LATCH);
      eoc = 1'b0;
      tick();
      chk("R5 go", V_CALC);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R5 go held", V_CALC);
      end
      pid_done = 1'b1;
      tick();
      chk("R6 write low", V_WRITE);
      pid_done = 1'b0;
      tick();
      chk("R6 start after write", V_START);
   endtask

   task automatic t_min_period();
      int gap;
      eoc = 1'b1; pid_done = 1'b1;
      for (int k = 0; k < 2; k++) begin
         gap = 0;
         do begin
            tick();
            gap++;
         end while (!cs0 && gap < 20);
         tests++;
         if (gap != 5) begin
            fails++;
            $display("FAIL R7: actual period %0d expected 5", gap);
         end
         chk("R7 start", V_START);
      end
      eoc = 1'b0; pid_done = 1'b0;
   endtask

   task automatic t_coincide();
      // machine is at start; next clock enters the wait
      tick();
      chk("R3 wait entered", V_IDLE);
      pid_done = 1'b1;
      tick(); tick();
      chk("R9 done ignored in wait", V_IDLE);
      eoc = 1'b1;
      tick();
      chk("R9 both high -> latch only", V_LATCH);
      eoc = 1'b0;
      tick();
      chk("R9 no skip past go", V_CALC);
      pid_done = 1'b0; eoc = 1'b1;
      tick(); tick();
      chk("R9 eoc ignored in compute", V_CALC);
      eoc = 1'b0; pid_done = 1'b1;
      tick();
      chk("R6 write", V_WRITE);
      pid_done = 1'b0;
      tick();
      chk("R6 restart", V_START);
   endtask

   task automatic t_midloop_reset();
      tick();
      eoc = 1'b1;
      tick();
      eoc = 1'b0;
      tick();
      chk("R5 go before reset", V_CALC);
      rst = 1'b1;
      pid_done = 1'b1;
      tick();
      chk("R1 reset aborts loop", V_IDLE);
      rst = 1'b0;
      pid_done = 1'b0;
      tick();
      chk("R1 restart after reset", V_START);
   endtask

   initial begin
      t_reset();
      t_single_loop();
      t_min_period();
      t_coincide();
      t_midloop_reset();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule